// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Master

This block drives a three-wire serial EEPROM that holds 64 words of 16 bits. It has four pins on the memory side: chip select, serial clock, data toward the memory and data from the memory. It makes the serial clock itself by dividing the system clock. A host issues one request at a time. A request is a 2-bit code, a 6-bit word address and a 16-bit word for writes. The block reports completion with a one-cycle done pulse. A read returns its word on a data output that holds its value until the next read.

A write request runs as one hardware transaction:

- a write-enable command;
- the write frame itself;
- a ready poll, in which chip select stays high while the memory's data line is clocked until it reads 1;
- a write-disable command.

If the memory never reports ready within a fixed number of polls, the poll is abandoned and an error flag is raised together with the done pulse. The write-disable command is still sent. Each command sits in its own chip-select frame, and chip select drops between frames.

Top module: `ee_serial_master`

## Requirements
- R1: Request codes on `op_i` are 0 read, 1 write, 2 write-enable, 3 write-disable. A request is taken only when `busy_o` is low. `busy_o` stays high from acceptance until completion. A request raised while `busy_o` is high has no effect on any pin.
- R2: A read drives one chip-select frame of 26 serial clocks. The bits are 0, 1, 1, 0, then the address MSB first, then 16 clocks during which the memory's data is sampled on each rising serial clock, MSB first. The word appears on `rdata_o` by the done pulse.
- R3: A write runs four chip-select frames in this order:
  - write-enable (1, 0, 0, 1, 1, four 0s: 9 clocks);
  - write (1, 0, 1, address MSB first, data MSB first: 25 clocks);
  - ready poll;
  - write-disable (1, then eight 0s: 9 clocks).
- R4: The ready poll gives one serial clock per poll with chip select held high. It stops at the first poll that samples 1. After `POLL_LIMIT` polls that all sample 0, it stops, and `err_o` is high at the done pulse. The write-disable frame follows in both cases.
- R5: A standalone write-enable or write-disable request sends only its own 9-clock frame, in one chip-select frame.
- R6: The serial clock is high only while chip select is high. Between two frames of one transaction, chip select is low for at least one serial bit period (`DIV` system clocks).
- R7: Each serial clock high phase lasts `DIV/2` system clocks. The data toward the memory changes only while the serial clock is low.
- R8: `done_o` is a single-cycle pulse with `busy_o` already low. `err_o` holds its value until the next accepted request, which clears it.
- R9: While reset is active, and directly after it, chip select, serial clock, data toward the memory, `busy_o`, `done_o` and `err_o` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request strobe, taken when idle |
| op_i | input | 2 | Request code (0 read, 1 write, 2 write-enable, 3 write-disable) |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Word to write |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Ready poll timed out in the last write |
| rdata_o | output | DATA_W | Last word read |
| ee_cs_o | output | 1 | Memory chip select |
| ee_sclk_o | output | 1 | Memory serial clock |
| ee_do_o | output | 1 | Serial data toward the memory |
| ee_di_i | input | 1 | Serial data from the memory |

## Verification
The following are checked on every cycle:

- the pin-level rules: the serial clock stays inside chip select, the outgoing data holds still across each high phase, and each high phase has the length `DIV/2`;
- that a request raised while busy leaves the latched request untouched;
- that the poll count never passes its limit;
- that the error flag only rises together with the done pulse.

The frame contents and their order can only be shown by the bench's scenarios. These cover the bit patterns, the write-enable / write / poll / write-disable sequence, the exact clock counts, the read data returned, the timeout path with its trailing write-disable, and the state a behavioural memory model is left in.

// File: rtl/ee_pkg.sv
package ee_pkg;
  typedef enum logic [1:0] {
    REQ_READ  = 2'd0,
    REQ_WRITE = 2'd1,
    REQ_WREN  = 2'd2,
    REQ_WRDIS = 2'd3
  } ee_req_e;

  typedef enum logic [2:0] {
    PH_WREN  = 3'd0,
    PH_WRITE = 3'd1,
    PH_POLL  = 3'd2,
    PH_WRDIS = 3'd3,
    PH_READ  = 3'd4
  } ee_phase_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_GAP   = 2'd2
  } ee_state_e;
endpackage

// File: rtl/ee_phase_timer.sv
module ee_phase_timer #(
  parameter int DIV = 8,
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i)                      cnt_d = '0;
    else if (cnt_q == CW'(DIV - 1))  cnt_d = '0;
    else                             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/ee_bit_shifter.sv
module ee_bit_shifter #(
  parameter int DIV = 8,
  parameter int FW  = 26,
  parameter int NW  = 5,
  parameter int DW  = 16,
  localparam int HALF = DIV / 2,
  localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1,
  localparam int HW   = $clog2(DIV + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [FW-1:0] frame_i,
  input  logic [NW-1:0] nbits_i,
  input  logic          di_i,
  output logic          sclk_o,
  output logic          do_o,
  output logic          done_o,
  output logic [DW-1:0] rx_o
);
  logic [FW-1:0] sh_q, sh_d;
  logic [NW-1:0] left_q, left_d;
  logic          act_q, act_d;
  logic          sclk_q, sclk_d;
  logic          done_q, done_d;
  logic [DW-1:0] rx_q, rx_d;
  logic [CW-1:0] ph_cnt;
  logic          rise_en, fall_en;

  ee_phase_timer #(.DIV(DIV)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run_i (act_q),
    .cnt_o (ph_cnt)
  );

  assign rise_en = act_q && (ph_cnt == CW'(HALF - 1));
  assign fall_en = act_q && (ph_cnt == CW'(DIV - 1));

  always_comb begin
    sh_d   = sh_q;
    left_d = left_q;
    act_d  = act_q;
    sclk_d = sclk_q;
    rx_d   = rx_q;
    done_d = 1'b0;
    if (start_i && !act_q) begin
      sh_d   = frame_i;
      left_d = nbits_i;
      act_d  = 1'b1;
      sclk_d = 1'b0;
    end else begin
      if (rise_en) begin
        sclk_d = 1'b1;
        rx_d   = {rx_q[DW-2:0], di_i};
      end
      if (fall_en) begin
        sclk_d = 1'b0;
        sh_d   = {sh_q[FW-2:0], 1'b0};
        if (left_q == NW'(1)) begin
          act_d  = 1'b0;
          done_d = 1'b1;
        end else begin
          left_d = left_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
      act_q  <= 1'b0;
      sclk_q <= 1'b0;
      done_q <= 1'b0;
      rx_q   <= '0;
    end else begin
      sh_q   <= sh_d;
      left_q <= left_d;
      act_q  <= act_d;
      sclk_q <= sclk_d;
      done_q <= done_d;
      rx_q   <= rx_d;
    end
  end

  assign sclk_o = sclk_q;
  assign do_o   = act_q & sh_q[FW-1];
  assign done_o = done_q;
  assign rx_o   = rx_q;

  // Length of the current serial clock high phase, in system clocks.
  logic [HW-1:0] hi_len_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hi_len_q <= '0;
    else if (sclk_q) hi_len_q <= hi_len_q + 1'b1;
    else             hi_len_q <= '0;
  end

  assert_do_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_q && $past(sclk_q)) |-> $stable(do_o));

  assert_high_half_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk_q) |-> (hi_len_q == HW'(HALF)));
endmodule

// File: rtl/ee_txn_seq.sv
module ee_txn_seq
  import ee_pkg::*;
#(
  parameter int DIV        = 8,
  parameter int POLL_LIMIT = 10000,
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 16,
  localparam int FW  = 4 + ADDR_W + DATA_W,
  localparam int NW  = $clog2(FW + 1),
  localparam int CW  = (DIV > 2) ? $clog2(DIV) : 1,
  localparam int PCW = $clog2(POLL_LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [1:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              cs_o,
  output logic              sh_start_o,
  output logic [FW-1:0]     sh_frame_o,
  output logic [NW-1:0]     sh_nbits_o,
  input  logic              sh_done_i,
  input  logic [DATA_W-1:0] sh_rx_i
);
  ee_state_e         state_q, state_d;
  ee_phase_e         phase_q, phase_d;
  ee_req_e           op_q, op_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic [PCW-1:0]    poll_q, poll_d;
  logic              launch_q, launch_d;
  logic              done_q, done_d;
  logic              tmo_q, tmo_d;
  logic              err_q, err_d;
  logic [CW-1:0]     gap_cnt;
  logic              gap_end;

  ee_phase_timer #(.DIV(DIV)) u_gap_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run_i (state_q == ST_GAP),
    .cnt_o (gap_cnt)
  );

  assign gap_end = (state_q == ST_GAP) && (gap_cnt == CW'(DIV - 1));

  // Frame bits, MSB first, left aligned in FW bits.
  always_comb begin
    sh_frame_o = '0;
    sh_nbits_o = NW'(1);
    unique case (phase_q)
      PH_READ: begin
        sh_frame_o = {1'b0, 1'b1, 2'b10, addr_q, {DATA_W{1'b0}}};
        sh_nbits_o = NW'(FW);
      end
      PH_WRITE: begin
        sh_frame_o = {1'b1, 2'b01, addr_q, wdata_q, 1'b0};
        sh_nbits_o = NW'(FW - 1);
      end
      PH_WREN: begin
        sh_frame_o = {1'b1, 2'b00, 2'b11, {(ADDR_W-2){1'b0}}, {(DATA_W+1){1'b0}}};
        sh_nbits_o = NW'(3 + ADDR_W);
      end
      PH_WRDIS: begin
        sh_frame_o = {1'b1, 2'b00, {ADDR_W{1'b0}}, {(DATA_W+1){1'b0}}};
        sh_nbits_o = NW'(3 + ADDR_W);
      end
      default: begin
        sh_frame_o = '0;
        sh_nbits_o = NW'(1);
      end
    endcase
  end

  always_comb begin
    state_d  = state_q;
    phase_d  = phase_q;
    op_d     = op_q;
    addr_d   = addr_q;
    wdata_d  = wdata_q;
    rdata_d  = rdata_q;
    poll_d   = poll_q;
    tmo_d    = tmo_q;
    err_d    = err_q;
    launch_d = 1'b0;
    done_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_i) begin
          op_d     = ee_req_e'(op_i);
          addr_d   = addr_i;
          wdata_d  = wdata_i;
          err_d    = 1'b0;
          tmo_d    = 1'b0;
          poll_d   = '0;
          state_d  = ST_SHIFT;
          launch_d = 1'b1;
          unique case (ee_req_e'(op_i))
            REQ_READ:  phase_d = PH_READ;
            REQ_WRDIS: phase_d = PH_WRDIS;
            default:   phase_d = PH_WREN;
          endcase
        end
      end
      ST_SHIFT: begin
        if (sh_done_i) begin
          if (phase_q == PH_POLL) begin
            poll_d = poll_q + 1'b1;
            if (sh_rx_i[0]) begin
              state_d = ST_GAP;
            end else if (poll_q == PCW'(POLL_LIMIT - 1)) begin
              tmo_d   = 1'b1;
              state_d = ST_GAP;
            end else begin
              launch_d = 1'b1;
            end
          end else begin
            if (phase_q == PH_READ) rdata_d = sh_rx_i;
            state_d = ST_GAP;
          end
        end
      end
      ST_GAP: begin
        if (gap_end) begin
          state_d  = ST_SHIFT;
          launch_d = 1'b1;
          unique case (phase_q)
            PH_WREN: begin
              if (op_q == REQ_WRITE) begin
                phase_d = PH_WRITE;
              end else begin
                state_d  = ST_IDLE;
                launch_d = 1'b0;
                done_d   = 1'b1;
                err_d    = tmo_q;
              end
            end
            PH_WRITE: phase_d = PH_POLL;
            PH_POLL:  phase_d = PH_WRDIS;
            default: begin
              state_d  = ST_IDLE;
              launch_d = 1'b0;
              done_d   = 1'b1;
              err_d    = tmo_q;
            end
          endcase
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      phase_q  <= PH_READ;
      op_q     <= REQ_READ;
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      poll_q   <= '0;
      tmo_q    <= 1'b0;
      err_q    <= 1'b0;
      launch_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      phase_q  <= phase_d;
      op_q     <= op_d;
      addr_q   <= addr_d;
      wdata_q  <= wdata_d;
      rdata_q  <= rdata_d;
      poll_q   <= poll_d;
      tmo_q    <= tmo_d;
      err_q    <= err_d;
      launch_q <= launch_d;
      done_q   <= done_d;
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign cs_o       = (state_q == ST_SHIFT);
  assign sh_start_o = launch_q;
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign rdata_o    = rdata_q;

  assert_ignore_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && req_i) |=> ($stable(op_q) && $stable(addr_q) && $stable(wdata_q)));

  assert_poll_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    poll_q <= PCW'(POLL_LIMIT));

  assert_err_with_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> done_o);

  assert_done_after_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));
endmodule

// File: rtl/ee_serial_master.sv
module ee_serial_master #(
  parameter int DIV        = 8,
  parameter int POLL_LIMIT = 10000,
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [1:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ee_cs_o,
  output logic              ee_sclk_o,
  output logic              ee_do_o,
  input  logic              ee_di_i
);
  localparam int FW = 4 + ADDR_W + DATA_W;
  localparam int NW = $clog2(FW + 1);

  // Reset asserts at once and is released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic              sh_start;
  logic [FW-1:0]     sh_frame;
  logic [NW-1:0]     sh_nbits;
  logic              sh_done;
  logic [DATA_W-1:0] sh_rx;

  ee_txn_seq #(
    .DIV(DIV), .POLL_LIMIT(POLL_LIMIT), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .req_i      (req_i),
    .op_i       (op_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o),
    .rdata_o    (rdata_o),
    .cs_o       (ee_cs_o),
    .sh_start_o (sh_start),
    .sh_frame_o (sh_frame),
    .sh_nbits_o (sh_nbits),
    .sh_done_i  (sh_done),
    .sh_rx_i    (sh_rx)
  );

  ee_bit_shifter #(
    .DIV(DIV), .FW(FW), .NW(NW), .DW(DATA_W)
  ) u_shift (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start_i (sh_start),
    .frame_i (sh_frame),
    .nbits_i (sh_nbits),
    .di_i    (ee_di_i),
    .sclk_o  (ee_sclk_o),
    .do_o    (ee_do_o),
    .done_o  (sh_done),
    .rx_o    (sh_rx)
  );

  assert_sclk_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    !ee_cs_o |-> !ee_sclk_o);
endmodule

// File: tb/sim_ee_serial_master.sv
module sim_ee_serial_master;
  localparam int CLK_PERIOD = 10;
  localparam int DIV  = 8;
  localparam int PLIM = 40;

  logic        clk, rst_n, req;
  logic [1:0]  op;
  logic [5:0]  addr;
  logic [15:0] wdata;
  logic        busy, done, err;
  logic [15:0] rdata;
  logic        cs, sclk, sdo, sdi;

  ee_serial_master #(.DIV(DIV), .POLL_LIMIT(PLIM), .ADDR_W(6), .DATA_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req), .op_i(op), .addr_i(addr),
    .wdata_i(wdata), .busy_o(busy), .done_o(done), .err_o(err),
    .rdata_o(rdata), .ee_cs_o(cs), .ee_sclk_o(sclk), .ee_do_o(sdo),
    .ee_di_i(sdi)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural memory model.
  logic [15:0] mem [64];
  int          busy_cnt = 0;
  int          busy_k   = 3;
  logic        started  = 1'b0;
  logic        reading  = 1'b0;
  logic        wr_en    = 1'b0;
  int          bitcnt   = 0;
  logic [23:0] rxs      = '0;
  logic [15:0] rd_word  = '0;
  logic        di_r     = 1'b0;
  int          rises    = 0;
  int          cs_rises = 0;

  assign sdi = reading ? di_r : ((cs && !started) ? (busy_cnt == 0) : 1'b0);

  always @(posedge sclk or negedge cs) begin
    if (!cs) begin
      started = 1'b0;
      reading = 1'b0;
    end else begin
      rises++;
      if (!started) begin
        if (sdo) begin
          started = 1'b1;
          bitcnt  = 0;
        end else if (busy_cnt > 0) begin
          busy_cnt--;
        end
      end else begin
        rxs = {rxs[22:0], sdo};
        bitcnt++;
        if (bitcnt == 8) begin
          if (rxs[7:6] == 2'b10) begin
            reading = 1'b1;
            rd_word = mem[rxs[5:0]];
          end else if (rxs[7:6] == 2'b00) begin
            if (rxs[5:4] == 2'b11) wr_en = 1'b1;
            else if (rxs[5:4] == 2'b00) wr_en = 1'b0;
          end
        end
        if (bitcnt == 24 && rxs[23:22] == 2'b01) begin
          if (wr_en) mem[rxs[21:16]] = rxs[15:0];
          busy_cnt = busy_k;
        end
      end
    end
  end

  always @(negedge sclk) begin
    if (reading && bitcnt >= 8 && bitcnt <= 23) di_r = rd_word[23 - bitcnt];
  end

  always @(posedge cs) cs_rises++;

  // Pin-level monitors sampled between edges.
  int   hi_cycles = 0;
  int   do_viol = 0;
  int   sclk_viol = 0;
  int   low_run = 0;
  int   min_gap = 1000000;
  logic prev_sclk = 1'b0;
  logic prev_do = 1'b0;
  int   cyc = 0;

  always @(negedge clk) begin
    cyc++;
    if (sclk) hi_cycles++;
    if (sclk && prev_sclk && (sdo !== prev_do)) do_viol++;
    if (sclk && !cs) sclk_viol++;
    if (!cs) begin
      low_run++;
    end else begin
      if (low_run > 0 && low_run < min_gap) min_gap = low_run;
      low_run = 0;
    end
    prev_sclk = sclk;
    prev_do   = sdo;
  end

  int tests = 0;
  int fails = 0;

  always @(negedge clk) begin
    if (cyc > 150000) begin
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails + 1);
      $finish;
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  int          t_rises, t_cs, t_hi;
  logic        t_err, t_done;
  logic [15:0] t_rd;

  task automatic txn(input logic [1:0] o, input logic [5:0] a, input logic [15:0] d);
    int r0, c0, h0, n;
    r0 = rises; c0 = cs_rises; h0 = hi_cycles;
    @(negedge clk);
    req = 1'b1; op = o; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0;
    n = 0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
    end
    t_done  = done;
    t_err   = err;
    t_rd    = rdata;
    t_rises = rises - r0;
    t_cs    = cs_rises - c0;
    t_hi    = hi_cycles - h0;
  endtask

  // op, addr, wdata, expected read word, serial clocks, chip-select frames
  localparam logic [55:0] VEC [9] = '{
    {2'd1, 6'h05, 16'hA5C3, 16'h0000, 8'd47, 8'd4},
    {2'd1, 6'h3F, 16'h1234, 16'h0000, 8'd47, 8'd4},
    {2'd1, 6'h00, 16'hFFFF, 16'h0000, 8'd47, 8'd4},
    {2'd0, 6'h05, 16'h0000, 16'hA5C3, 8'd26, 8'd1},
    {2'd0, 6'h3F, 16'h0000, 16'h1234, 8'd26, 8'd1},
    {2'd0, 6'h00, 16'h0000, 16'hFFFF, 8'd26, 8'd1},
    {2'd0, 6'h10, 16'h0000, 16'h4A10, 8'd26, 8'd1},
    {2'd1, 6'h3F, 16'h0001, 16'h0000, 8'd47, 8'd4},
    {2'd0, 6'h3F, 16'h0000, 16'h0001, 8'd26, 8'd1}
  };

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 16'(i * 257) ^ 16'h5A00;
    rst_n = 1'b0; req = 1'b0; op = 2'd0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    // R9: outputs while reset is held
    chk("R9 cs in reset", cs, 0);
    chk("R9 sclk in reset", sclk, 0);
    chk("R9 do in reset", sdo, 0);
    chk("R9 busy in reset", busy, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 done after reset", done, 0);
    chk("R9 err after reset", err, 0);
    chk("R9 busy after reset", busy, 0);

    // Table walk: writes then read-back (R2, R3)
    for (int i = 0; i < 9; i++) begin
      txn(VEC[i][55:54], VEC[i][53:48], VEC[i][47:32]);
      chk("R8 done seen", t_done, 1);
      chk("R4 err clear", t_err, 0);
      if (VEC[i][55:54] == 2'd1) begin
        chk("R3 write clocks", t_rises, VEC[i][15:8]);
        chk("R3 write frames", t_cs, VEC[i][7:0]);
        chk("R3 disable after write", wr_en, 0);
      end else begin
        chk("R2 read clocks", t_rises, VEC[i][15:8]);
        chk("R2 read frames", t_cs, VEC[i][7:0]);
        chk("R2 read data", t_rd, VEC[i][31:16]);
      end
    end

    // R7: high time over a whole read is 26 * DIV/2
    txn(2'd0, 6'h05, 16'h0);
    chk("R7 high cycles", t_hi, 26 * (DIV / 2));
    chk("R7 do moved while sclk high", do_viol, 0);
    chk("R6 sclk outside cs", sclk_viol, 0);
    chk("R6 gap >= DIV", (min_gap >= DIV) ? 1 : 0, 1);

    // R8: done lasts one cycle
    @(negedge clk);
    chk("R8 done one cycle", done, 0);
    chk("R8 busy low after done", busy, 0);

    // R5: standalone write-enable and write-disable
    txn(2'd2, 6'h00, 16'h0);
    chk("R5 enable clocks", t_rises, 9);
    chk("R5 enable frames", t_cs, 1);
    chk("R5 enable latched", wr_en, 1);
    txn(2'd3, 6'h00, 16'h0);
    chk("R5 disable clocks", t_rises, 9);
    chk("R5 disable latched", wr_en, 0);

    // R4: ready on the first poll
    busy_k = 0;
    txn(2'd1, 6'h02, 16'h0F0F);
    chk("R4 first-poll clocks", t_rises, 44);
    chk("R4 first-poll err", t_err, 0);

    // R4: timeout, still followed by write-disable
    busy_k = 100000;
    txn(2'd1, 6'h07, 16'hBEEF);
    chk("R4 timeout err", t_err, 1);
    chk("R4 timeout clocks", t_rises, 9 + 25 + PLIM + 9);
    chk("R4 timeout frames", t_cs, 4);
    chk("R4 disable after timeout", wr_en, 0);
    chk("R8 err held", err, 1);
    busy_k = 3;

    // R8: next accepted request clears err
    txn(2'd0, 6'h07, 16'h0);
    chk("R8 err cleared", t_err, 0);
    chk("R2 read after timeout", t_rd, 16'hBEEF);

    // R1: a request while busy is ignored
    begin
      int r0, c0, n;
      r0 = rises; c0 = cs_rises;
      @(negedge clk);
      req = 1'b1; op = 2'd0; addr = 6'h05;
      @(negedge clk);
      req = 1'b0;
      repeat (30) @(negedge clk);
      chk("R1 busy during read", busy, 1);
      req = 1'b1; op = 2'd1; addr = 6'h05; wdata = 16'h0000;
      @(negedge clk);
      req = 1'b0;
      n = 0;
      while (!done && n < 20000) begin
        @(negedge clk);
        n++;
      end
      chk("R1 read data kept", rdata, 16'hA5C3);
      repeat (60) @(negedge clk);
      chk("R1 no extra clocks", rises - r0, 26);
      chk("R1 no extra frames", cs_rises - c0, 1);
      chk("R1 idle after", busy, 0);
    end
    txn(2'd0, 6'h05, 16'h0);
    chk("R1 memory untouched", t_rd, 16'hA5C3);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule